// File: doc/BRIEF.md
# Bus-Paced Successive-Approximation Conversion Sequencer

This block holds the digital control of an 8-bit successive-approximation converter whose conversions are paced by read transfers on a serial bus. The bus front end gives one trigger pulse on the trailing edge of each acknowledge clock during a read. The same pulse marks the point where the outgoing byte must be loaded. The trigger loads the transmit byte from the data register. The sequencer then asks the sample-and-hold to capture the selected channel, and searches the code with one comparator decision per clock. The code found is stored as the next result. Each byte on the bus therefore carries the result of the conversion before it.

The channel is chosen by a configuration write, which also sets the input mode and the auto-advance flag. The input mode sets how many channels exist and which of them are differential. Differential results are given in two's complement. Single-ended results are given in plain binary. When a trigger arrives in the last search step, the finished result is forwarded into the transmit byte at once, so conversions can run back to back with no idle clock.

Top module: `sar_read_ctrl`

## Requirements
- R1: While rst_ni is low, tx_byte_o is 0x00, chan_o is 0, and busy_o, sh_sample_o, done_o and tx_load_o are 0.
- R2: The data register resets to 0x80. The first triggered read after reset therefore loads 0x80 into tx_byte_o.
- R3: A trigger starts a conversion only when read_mode_i is high. A trigger with read_mode_i low has no effect on any output.
- R4: An accepted trigger raises sh_sample_o in the next cycle, for exactly one cycle, with busy_o high. chan_o selects the channel to sample during that cycle.
- R5: The search runs MSB first over 8 step cycles. The first trial code on dac_code_o is 0x80. A trial bit is kept when cmp_i is high, meaning the input is at or above the trial level. The result equals the held input level.
- R6: An accepted trigger loads tx_byte_o from the data register and pulses tx_load_o for one cycle. tx_byte_o changes at no other time.
- R7: Input modes (cfg_mode_i): 0 gives four single-ended channels. 1 gives three differential channels. 2 gives channels 0 and 1 single-ended and channel 2 differential. 3 gives two differential channels. A differential result has its MSB inverted (offset binary to two's complement).
- R8: busy_o stays high for 9 cycles per conversion (1 sample cycle and 8 step cycles). done_o pulses for one cycle in the cycle after the last step, and the data register then holds the new result.
- R9: With cfg_autoinc_i high, chan_o advances by one when a conversion completes. It wraps to 0 from the last channel of the mode (channel count 4, 3, 3 or 2 for modes 0 to 3). With the flag low, chan_o is unchanged.
- R10: cfg_wr_i loads chan_o from cfg_chan_i on the next clock. The load takes priority over an advance in the same cycle.
- R11: A trigger that arrives while busy_o is high, other than in the last step cycle, is ignored.
- R12: A trigger in the last step cycle is accepted. tx_byte_o receives the result completing in that cycle, and the next sample cycle follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| read_mode_i | input | 1 | Current transfer was addressed in read mode |
| ack_trig_i | input | 1 | Pulse at the trailing edge of the acknowledge clock |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_chan_i | input | 2 | Channel index to load |
| cfg_mode_i | input | 2 | Input mode |
| cfg_autoinc_i | input | 1 | Auto-advance channel after each conversion |
| cmp_i | input | 1 | Comparator: held input at or above trial level |
| sh_sample_o | output | 1 | Sample-and-hold capture strobe |
| dac_code_o | output | 8 | Trial code to the internal DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse after the last search step |
| tx_load_o | output | 1 | One-cycle pulse when the transmit byte is loaded |
| tx_byte_o | output | 8 | Byte to shift out on the bus |
| chan_o | output | 2 | Selected analog channel |

## Verification
Two events can fall in the same clock edge: a conversion completing (data register write and channel advance) and a new read trigger (transmit load and restart). The bench provokes this by raising the trigger exactly in the last step cycle of running conversions, several times in a row, and by raising a configuration write on that same edge. A behavioural model built from a step counter and the analog levels judges the outcome. The forwarded byte must be the result just completed, not the stale one. The new conversion must sample the advanced channel, and the configuration write must win over the advance.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_STEP} sar_state_e;

  function automatic logic [2:0] chan_count(input logic [1:0] mode);
    case (mode)
      2'd0:    return 3'd4;
      2'd1:    return 3'd3;
      2'd2:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic chan_is_diff(input logic [1:0] mode, input logic [1:0] ch);
    case (mode)
      2'd0:    return 1'b0;
      2'd2:    return ch == 2'd2;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             cmp_i,
  input  logic             diff_i,
  output logic             busy_o,
  output logic             sample_o,
  output logic             fin_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int IW = $clog2(WIDTH);

  sar_state_e       state_q;
  logic [IW-1:0]    idx_q;
  logic [WIDTH-1:0] code_q, bit_sel, trial, raw;
  logic             diff_q;

  assign bit_sel    = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;
  assign trial      = code_q | bit_sel;
  assign busy_o     = state_q != ST_IDLE;
  assign sample_o   = state_q == ST_SAMPLE;
  assign fin_o      = (state_q == ST_STEP) && (idx_q == '0);
  assign dac_code_o = (state_q == ST_STEP) ? trial : '0;
  assign raw        = cmp_i ? trial : code_q;
  // differential: offset binary -> two's complement
  assign result_o   = diff_q ? {~raw[WIDTH-1], raw[WIDTH-2:0]} : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
      diff_q  <= 1'b0;
    end else if (accept_i) begin
      state_q <= ST_SAMPLE;
    end else begin
      case (state_q)
        ST_SAMPLE: begin
          state_q <= ST_STEP;
          idx_q   <= IW'(WIDTH - 1);
          code_q  <= '0;
          diff_q  <= diff_i;
        end
        ST_STEP: begin
          code_q <= raw;
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_chan.sv
module sar_chan
  import sar_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] chan_i,
  input  logic [1:0] mode_i,
  input  logic       autoinc_i,
  input  logic       adv_i,
  output logic [1:0] chan_o
);
  logic [2:0] last;
  assign last = chan_count(mode_i) - 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chan_o <= '0;
    else if (wr_i)              chan_o <= chan_i;
    else if (adv_i && autoinc_i)
      chan_o <= ({1'b0, chan_o} >= last) ? 2'd0 : chan_o + 2'd1;
  end
endmodule

// File: rtl/sar_outreg.sv
module sar_outreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             fin_i,
  input  logic [WIDTH-1:0] result_i,
  output logic [WIDTH-1:0] tx_o,
  output logic             load_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] POR_VAL = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= POR_VAL;
      tx_o   <= '0;
      load_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      load_o <= accept_i;
      done_o <= fin_i;
      if (fin_i)    data_q <= result_i;
      // forward a result completing on the same edge
      if (accept_i) tx_o <= fin_i ? result_i : data_q;
    end
  end
endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             read_mode_i,
  input  logic             ack_trig_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_chan_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_autoinc_i,
  input  logic             cmp_i,
  output logic             sh_sample_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             tx_load_o,
  output logic [WIDTH-1:0] tx_byte_o,
  output logic [1:0]       chan_o
);
  logic             accept, fin, diff;
  logic [WIDTH-1:0] result;

  assign accept = read_mode_i && ack_trig_i && (!busy_o || fin);
  assign diff   = chan_is_diff(cfg_mode_i, chan_o);

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .cmp_i,
    .diff_i    (diff),
    .busy_o,
    .sample_o  (sh_sample_o),
    .fin_o     (fin),
    .dac_code_o,
    .result_o  (result)
  );

  sar_chan u_chan (
    .clk_i, .rst_ni,
    .wr_i      (cfg_wr_i),
    .chan_i    (cfg_chan_i),
    .mode_i    (cfg_mode_i),
    .autoinc_i (cfg_autoinc_i),
    .adv_i     (fin),
    .chan_o
  );

  sar_outreg #(.WIDTH(WIDTH)) u_out (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .fin_i     (fin),
    .result_i  (result),
    .tx_o      (tx_byte_o),
    .load_o    (tx_load_o),
    .done_o
  );
endmodule

// File: rtl/sar_read_ctrl_chk.sv
module sar_read_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             read_mode_i,
  input logic             ack_trig_i,
  input logic             cfg_wr_i,
  input logic             sh_sample_o,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             tx_load_o,
  input logic [WIDTH-1:0] tx_byte_o,
  input logic [1:0]       chan_o
);
  localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  assert_write_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ack_trig_i && !read_mode_i) |=> !sh_sample_o && !tx_load_o);

  assert_sample_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_sample_o |=> !sh_sample_o && busy_o);

  assert_first_trial_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_sample_o |=> dac_code_o == FIRST_TRIAL);

  assert_load_on_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_mode_i && ack_trig_i && !busy_o) |=> tx_load_o && sh_sample_o);

  assert_tx_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tx_load_o || $stable(tx_byte_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_chan_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(chan_o) || done_o);
endmodule

bind sar_read_ctrl sar_read_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .read_mode_i (read_mode_i),
  .ack_trig_i  (ack_trig_i),
  .cfg_wr_i    (cfg_wr_i),
  .sh_sample_o (sh_sample_o),
  .dac_code_o  (dac_code_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tx_load_o   (tx_load_o),
  .tx_byte_o   (tx_byte_o),
  .chan_o      (chan_o)
);

// File: tb/sar_read_ctrl_tb.sv
module sar_read_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 1'b0, trig = 1'b0, wr = 1'b0, ai = 1'b0;
  logic [1:0] cch = 2'd0, cmode = 2'd0;
  logic       cmp;
  logic       smp, busy, done, load;
  logic [7:0] dac, tx;
  logic [1:0] chan;

  always #10 clk = ~clk;

  sar_read_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .read_mode_i(rd), .ack_trig_i(trig),
    .cfg_wr_i(wr), .cfg_chan_i(cch), .cfg_mode_i(cmode), .cfg_autoinc_i(ai),
    .cmp_i(cmp), .sh_sample_o(smp), .dac_code_o(dac), .busy_o(busy),
    .done_o(done), .tx_load_o(load), .tx_byte_o(tx), .chan_o(chan)
  );

  int n_tot = 0, n_fail = 0, cyc = 0;
  int vin [4];

  // behavioural reference model
  int m_cnt = -1, m_held = 0, m_data = 128, m_tx = 0, m_chan = 0;
  int m_done = 0, m_load = 0, m_res = 0;
  bit m_diff = 0;

  function automatic int cnt_of(int md);
    return (md == 0) ? 4 : (md == 3) ? 2 : 3;
  endfunction
  function automatic bit diff_of(int md, int ch);
    return (md == 1) || (md == 3) || (md == 2 && ch == 2);
  endfunction

  assign cmp = (m_held >= int'(dac));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = -1; m_data = 128; m_tx = 0; m_chan = 0; m_done = 0; m_load = 0;
    end else begin
      bit fin, acc;
      int nchan;
      fin = (m_cnt == 8);
      acc = rd && trig && (m_cnt < 0 || fin);
      m_res = m_diff ? (m_held ^ 128) : m_held;
      m_load = acc;
      if (acc) m_tx = fin ? m_res : m_data;
      m_done = fin;
      if (fin) m_data = m_res;
      nchan = m_chan;
      if (wr) nchan = cch;
      else if (fin && ai) nchan = (m_chan >= cnt_of(cmode) - 1) ? 0 : m_chan + 1;
      if (m_cnt == 0) begin
        m_held = vin[m_chan];
        m_diff = diff_of(cmode, m_chan);
      end
      m_chan = nchan;
      if (acc) m_cnt = 0;
      else if (m_cnt >= 0 && m_cnt < 8) m_cnt++;
      else m_cnt = -1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tot++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 tx_byte", tx, m_tx);
      chk("R6 tx_load", load, m_load);
      chk("R9 chan", chan, m_chan);
      chk("R8 busy", busy, m_cnt >= 0);
      chk("R8 done", done, m_done);
      chk("R4 sample", smp, m_cnt == 0);
      if (m_cnt == 1) chk("R5 first trial", dac, 8'h80);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tot++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  task automatic pulse(logic r);
    @(negedge clk); rd = r; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask
  task automatic wait_idle();
    while (m_cnt >= 0) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic cfg(int md, int ch, logic inc);
    @(negedge clk); cmode = 2'(md); cch = 2'(ch); ai = inc; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic wait_last();
    while (m_cnt != 8) @(negedge clk);
  endtask

  initial begin
    vin[0] = 8'h5A; vin[1] = 8'hC3; vin[2] = 8'h30; vin[3] = 8'h07;
    repeat (3) @(negedge clk);
    chk("R1 tx reset", tx, 8'h00);
    chk("R1 chan reset", chan, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 sample reset", smp, 0);
    rst_n = 1'b1;

    pulse(1'b0);
    chk("R3 write-mode sample", smp, 0);
    chk("R3 write-mode busy", busy, 0);

    pulse(1'b1);
    chk("R2 first byte", tx, 8'h80);
    wait_idle();
    pulse(1'b1);
    chk("R5 ch0 result", tx, 8'h5A);
    wait_idle();

    cfg(1, 1, 1'b1);
    pulse(1'b1); wait_idle();
    chk("R9 advance", chan, 2);
    pulse(1'b1);
    chk("R7 diff ch1", tx, 8'h43);
    wait_idle();
    chk("R9 wrap mode1", chan, 0);
    pulse(1'b1);
    chk("R7 diff ch2", tx, 8'hB0);
    wait_idle();

    // R11: trigger mid-conversion ignored
    cfg(2, 0, 1'b1);
    pulse(1'b1);
    while (m_cnt != 3) @(negedge clk);
    pulse(1'b1);
    chk("R11 ignored sample", smp, 0);
    wait_idle();

    // R12: back-to-back triggers on last step
    pulse(1'b1);
    for (int i = 0; i < 6; i++) begin
      wait_last();
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk("R12 forwarded", tx, m_data);
      chk("R12 restart", smp, 1);
    end
    wait_idle();

    // R10: configuration write on the completion edge
    cfg(0, 0, 1'b1);
    pulse(1'b1);
    wait_last();
    cch = 2'd3; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R10 write wins", chan, 3);
    wait_idle();

    cfg(3, 1, 1'b1);
    pulse(1'b1); wait_idle();
    chk("R9 wrap mode3", chan, 0);
    cfg(0, 2, 1'b0);
    pulse(1'b1); wait_idle();
    chk("R9 autoinc off", chan, 2);
    pulse(1'b1);
    chk("R5 ch2 single", tx, 8'h30);
    wait_idle();

    summary();
  end
endmodule